// File: doc/BRIEF.md
# Request/Acknowledge Handshake Monitor

This block watches a four-phase request/acknowledge handshake that carries data between clock domains. Both handshake lines are expected to be already synchronized into the monitor's own clock. The block only observes them. On every clock edge it samples `req` and `ack` and compares each with its value at the previous edge to find rising edges. It then steps a small tracker through three phases: quiet, waiting for the acknowledge, and waiting for both lines to return low.

Four kinds of protocol error each raise their own flag, and every flag stays set until reset:

- a second request while the previous transfer is not finished;
- an acknowledge with no request behind it;
- a request withdrawn before its acknowledge arrives;
- an acknowledge that takes longer than a limit supplied at a port.

Two saturating counters record how many request rises and acknowledge rises have been seen. Together they give a coverage measure of how much the handshake was exercised. An `idle` output shows when no transfer is in progress.

Top module: `hs_crossing_monitor`

## Requirements
- R1: After reset, all four error flags are 0, both counters are 0 and `idle` is 1.
- R2: A rise of `req` is an edge at which `req` is sampled 1 after being sampled 0 at the previous edge; a rise of `ack` is defined the same way. Each rise adds one to its counter (`req_count` or `ack_count`). The new count is visible after that edge.
- R3: Both counters saturate at all ones (2^CNT_W - 1) and never wrap.
- R4: `err_multi_req` is set when a rise of `req` is seen after the acknowledge for the current request has been seen, but before `req` and `ack` have both been sampled low again.
- R5: `err_ack_no_req` is set when a rise of `ack` is seen while no request is waiting. This covers the case where `idle` is 1, and also a second rise of `ack` after the current request has already been acknowledged.
- R6: `err_req_drop` is set when `req` is sampled low while a request is waiting for its acknowledge and no rise of `ack` is seen at that edge. The tracker then returns to idle.
- R7: `timeout_limit` = L. Count the edges that follow the edge that saw the rise of `req`. If no rise of `ack` is seen at any of the first L+1 of these edges, `err_ack_timeout` is set at edge L+1.
- R8: Once set, each error flag stays 1 until reset, whatever the later handshake activity.
- R9: `idle` goes to 0 at the edge that sees a rise of `req` from idle. After the acknowledge, it returns to 1 at the first edge where `req` and `ack` are both sampled 0.
- R10: A rise of `ack` seen exactly at edge L+1 after the rise of `req` is on time: `err_ack_timeout` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Observing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Synchronized request line |
| ack | input | 1 | Synchronized acknowledge line |
| timeout_limit | input | TMO_W | Acknowledge wait limit L, in clock edges (see R7) |
| err_multi_req | output | 1 | Sticky: second request before handshake return |
| err_ack_no_req | output | 1 | Sticky: acknowledge without a waiting request |
| err_req_drop | output | 1 | Sticky: request withdrawn before acknowledge |
| err_ack_timeout | output | 1 | Sticky: acknowledge later than the limit |
| req_count | output | CNT_W | Saturating count of request rises |
| ack_count | output | CNT_W | Saturating count of acknowledge rises |
| idle | output | 1 | No transfer in progress |

## Verification
Every result is registered. A rise on `req` or `ack` driven before a clock edge is sampled at that edge, and the new counts, flags and `idle` appear right after it. The bench therefore drives inputs on the falling edge and reads outputs on the next falling edge, exactly one edge later.

The timeout is tested at both sides of its boundary. With a limit of L, an acknowledge that rises at edge L+1 must leave the flag clear. A missing acknowledge must leave the flag clear after edge L and set it after edge L+1.

// File: rtl/hs_crossing_monitor.sv
module hs_crossing_monitor #(
  parameter int CNT_W = 32,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             ack,
  input  logic [TMO_W-1:0] timeout_limit,
  output logic             err_multi_req,
  output logic             err_ack_no_req,
  output logic             err_req_drop,
  output logic             err_ack_timeout,
  output logic [CNT_W-1:0] req_count,
  output logic [CNT_W-1:0] ack_count,
  output logic             idle
);

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_WAIT_ACK = 2'd1, S_WAIT_DROP = 2'd2} st_t;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  st_t              state;
  logic             req_q, ack_q;
  logic [TMO_W-1:0] timer;

  wire req_rise = req & ~req_q;
  wire ack_rise = ack & ~ack_q;

  assign idle = (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q     <= 1'b0;
      ack_q     <= 1'b0;
      req_count <= '0;
      ack_count <= '0;
    end else begin
      req_q <= req;
      ack_q <= ack;
      if (req_rise && req_count != CNT_MAX) req_count <= req_count + 1'b1;
      if (ack_rise && ack_count != CNT_MAX) ack_count <= ack_count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state           <= S_IDLE;
      timer           <= '0;
      err_multi_req   <= 1'b0;
      err_ack_no_req  <= 1'b0;
      err_req_drop    <= 1'b0;
      err_ack_timeout <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (ack_rise) err_ack_no_req <= 1'b1;
          if (req_rise) begin
            state <= S_WAIT_ACK;
            timer <= '0;
          end
        end
        S_WAIT_ACK: begin
          if (ack_rise) begin
            state <= S_WAIT_DROP;
            timer <= '0;
          end else if (!req) begin
            err_req_drop <= 1'b1;
            state        <= S_IDLE;
          end else if (timer == timeout_limit) begin
            err_ack_timeout <= 1'b1;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        S_WAIT_DROP: begin
          if (req_rise) err_multi_req  <= 1'b1;
          if (ack_rise) err_ack_no_req <= 1'b1;
          if (!req && !ack) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hs_crossing_monitor_chk.sv
module hs_crossing_monitor_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req,
  input logic             ack,
  input logic [1:0]       state,
  input logic             err_multi_req,
  input logic             err_ack_no_req,
  input logic             err_req_drop,
  input logic             err_ack_timeout,
  input logic [CNT_W-1:0] req_count,
  input logic [CNT_W-1:0] ack_count,
  input logic             idle
);
  localparam logic [1:0] ST_WAIT_ACK  = 2'd1;
  localparam logic [1:0] ST_WAIT_DROP = 2'd2;
  localparam logic [CNT_W-1:0] TOP = '1;

  AST_STICKY_MULTI:   assert property (@(posedge clk) disable iff (!rst_n) err_multi_req |=> err_multi_req);     // R8
  AST_STICKY_NOREQ:   assert property (@(posedge clk) disable iff (!rst_n) err_ack_no_req |=> err_ack_no_req);   // R8
  AST_STICKY_DROP:    assert property (@(posedge clk) disable iff (!rst_n) err_req_drop |=> err_req_drop);       // R8
  AST_STICKY_TMO:     assert property (@(posedge clk) disable iff (!rst_n) err_ack_timeout |=> err_ack_timeout); // R8
  AST_REQ_CNT_STEP:   assert property (@(posedge clk) disable iff (!rst_n)
                        1'b1 |=> (req_count == $past(req_count) || req_count == $past(req_count) + 1'b1));      // R2
  AST_ACK_CNT_STEP:   assert property (@(posedge clk) disable iff (!rst_n)
                        1'b1 |=> (ack_count == $past(ack_count) || ack_count == $past(ack_count) + 1'b1));      // R2
  AST_REQ_CNT_SAT:    assert property (@(posedge clk) disable iff (!rst_n) req_count == TOP |=> req_count == TOP); // R3
  AST_ACK_CNT_SAT:    assert property (@(posedge clk) disable iff (!rst_n) ack_count == TOP |=> ack_count == TOP); // R3
  AST_MULTI_FLAG:     assert property (@(posedge clk) disable iff (!rst_n)
                        (state == ST_WAIT_DROP && $rose(req)) |=> err_multi_req);                               // R4
  AST_DROP_FLAG:      assert property (@(posedge clk) disable iff (!rst_n)
                        (state == ST_WAIT_ACK && !req && !ack) |=> (err_req_drop && idle));                     // R6
endmodule

bind hs_crossing_monitor hs_crossing_monitor_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .ack(ack), .state(state),
  .err_multi_req(err_multi_req), .err_ack_no_req(err_ack_no_req),
  .err_req_drop(err_req_drop), .err_ack_timeout(err_ack_timeout),
  .req_count(req_count), .ack_count(ack_count), .idle(idle)
);

// File: tb/tb_hs_crossing_monitor.sv
module tb_hs_crossing_monitor;
  localparam int CW = 4;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic ack = 1'b0;
  logic [TW-1:0] limit = 16'd20;
  logic e_multi, e_noreq, e_drop, e_tmo, idle;
  logic [CW-1:0] rcnt, acnt;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  hs_crossing_monitor #(.CNT_W(CW), .TMO_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .ack(ack), .timeout_limit(limit),
    .err_multi_req(e_multi), .err_ack_no_req(e_noreq), .err_req_drop(e_drop),
    .err_ack_timeout(e_tmo), .req_count(rcnt), .ack_count(acnt), .idle(idle)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic flags_are(input string tag, input logic m, input logic n, input logic d, input logic t);
    check({tag, " multi"},   32'(e_multi), 32'(m));
    check({tag, " noreq"},   32'(e_noreq), 32'(n));
    check({tag, " drop"},    32'(e_drop),  32'(d));
    check({tag, " timeout"}, 32'(e_tmo),   32'(t));
  endtask

  task automatic do_reset();
    req = 1'b0; ack = 1'b0; rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic handshake();
    req = 1'b1; step(1);
    ack = 1'b1; step(1);
    req = 1'b0; step(1);
    ack = 1'b0; step(1);
  endtask

  task automatic t_reset();
    do_reset();
    flags_are("R1 reset", 0, 0, 0, 0);
    check("R1 req_count", 32'(rcnt), 0);
    check("R1 ack_count", 32'(acnt), 0);
    check("R1 idle", 32'(idle), 1);
  endtask

  task automatic t_good();
    do_reset(); limit = 16'd20;
    req = 1'b1; step(1);
    check("R2 req_count", 32'(rcnt), 1);
    check("R9 idle low", 32'(idle), 0);
    ack = 1'b1; step(1);
    check("R2 ack_count", 32'(acnt), 1);
    req = 1'b0; step(1);
    check("R9 idle while ack high", 32'(idle), 0);
    ack = 1'b0; step(1);
    check("R9 idle back", 32'(idle), 1);
    flags_are("R2 clean handshake", 0, 0, 0, 0);
  endtask

  task automatic t_limit_edge();
    do_reset(); limit = 16'd3;
    req = 1'b1; step(1);
    step(3);
    ack = 1'b1; step(1);
    check("R10 on-time ack", 32'(e_tmo), 0);
    req = 1'b0; step(1);
    ack = 1'b0; step(1);
    flags_are("R10 after", 0, 0, 0, 0);
  endtask

  task automatic t_timeout();
    do_reset(); limit = 16'd2;
    req = 1'b1; step(1);
    step(2);
    check("R7 not yet at edge L", 32'(e_tmo), 0);
    step(1);
    check("R7 timeout at edge L+1", 32'(e_tmo), 1);
    ack = 1'b1; step(1);
    req = 1'b0; step(1);
    ack = 1'b0; step(1);
    check("R8 timeout sticky", 32'(e_tmo), 1);
    limit = 16'd20;
  endtask

  task automatic t_ack_no_req();
    do_reset();
    ack = 1'b1; step(1);
    flags_are("R5 ack while idle", 0, 1, 0, 0);
    ack = 1'b0; step(1);
    handshake();
    check("R8 noreq sticky", 32'(e_noreq), 1);
    do_reset();
    req = 1'b1; step(1);
    ack = 1'b1; step(1);
    ack = 1'b0; step(1);
    ack = 1'b1; step(1);
    flags_are("R5 second ack", 0, 1, 0, 0);
  endtask

  task automatic t_drop();
    do_reset();
    req = 1'b1; step(1);
    req = 1'b0; step(1);
    flags_are("R6 drop", 0, 0, 1, 0);
    check("R6 idle after drop", 32'(idle), 1);
    handshake();
    check("R8 drop sticky", 32'(e_drop), 1);
  endtask

  task automatic t_multi();
    do_reset();
    req = 1'b1; step(1);
    ack = 1'b1; step(1);
    req = 1'b0; step(1);
    req = 1'b1; step(1);
    flags_are("R4 multi", 1, 0, 0, 0);
    check("R4 req_count", 32'(rcnt), 2);
  endtask

  task automatic t_saturate();
    do_reset(); limit = 16'd20;
    for (int i = 0; i < 20; i++) handshake();
    check("R3 req_count sat", 32'(rcnt), 15);
    check("R3 ack_count sat", 32'(acnt), 15);
    flags_are("R3 clean", 0, 0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_good();
    t_limit_edge();
    t_timeout();
    t_ack_no_req();
    t_drop();
    t_multi();
    t_saturate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule